// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block turns a fast peripheral clock into the low and high phases of a two-wire bus clock. A single configuration word sets the length of each phase as a divisor scaled by a power-of-two prescaler plus a fixed offset, and sets how long SDA is held after each falling SCL edge. The block drives a level that says whether SCL is released (high) or pulled low, and a one-cycle strobe that tells the bus sequencer when SDA may change.

A run input starts and stops the waveform; while stopped, SCL stays released. A stretch input reports that another device is holding SCL low, and it freezes the high-phase count until the line is free again. A new configuration word is only sampled when a phase starts, so a change never truncates or lengthens the phase in progress.

Top module: `scl_waveform_gen`

## Requirements
- R1: During and right after reset, and at every clock while run is low, `scl_o` is 1 and `sda_chg_o` is 0.
- R2: On the first clock edge at which run is sampled high after idle, `scl_o` goes to 0 and a low phase begins using the configuration sampled at that edge.
- R3: A phase lasts div × 2^exp + OFFSET clocks, where the low phase takes div from cfg bits 7:0, the high phase from cfg bits 15:8, and exp comes from cfg bits 18:16; phases alternate low, high, low.
- R4: When exp is above EXP_MAX, the phase uses exp = EXP_MAX and a divisor of 255, whatever the programmed divisor.
- R5: A divisor of 0 gives a phase of exactly OFFSET clocks.
- R6: `sda_chg_o` is a single-cycle pulse that rises HOLD + 3 clock edges after the edge at which `scl_o` fell, HOLD being cfg bits 29:24, provided HOLD + 3 does not exceed the low-phase length; it fires at most once per low phase.
- R7: When HOLD + 3 is larger than the low-phase length, no strobe is produced for that low phase.
- R8: While stretch is 1 during a high phase, the high-phase count is frozen and `scl_o` stays 1; stretch has no effect during a low phase.
- R9: A configuration change takes effect only at the next phase start; the phase in progress keeps its length and hold.
- R10: When run is sampled low, the block returns to idle at that edge: `scl_o` is 1 and `sda_chg_o` is 0 from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Generate the waveform while 1; idle while 0 |
| stretch_i | input | 1 | SCL held low by another device; freezes the high phase |
| cfg_i | input | CFG_W | Configuration: low div 7:0, high div 15:8, exponent 18:16, hold 29:24 |
| scl_o | output | 1 | 1 = SCL released (high phase or idle), 0 = SCL driven low |
| sda_chg_o | output | 1 | One-cycle strobe marking the SDA change point |

## Verification
Every output is registered, so an SCL transition shows one clock edge after the edge that ends a phase, and the SDA strobe appears HOLD + 3 edges after the edge at which SCL fell. The bench steps a behavioural model at each rising edge from the inputs held stable since the previous falling edge, and compares both outputs 1 ns after that edge, when the design's registers have settled. Inputs change only on falling edges, so configuration changes land mid-phase and expose any early sampling.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Field layout of the configuration word.
  localparam int DIV_W      = 8;
  localparam int LO_DIV_LSB = 0;
  localparam int HI_DIV_LSB = 8;
  localparam int EXP_LSB    = 16;
  localparam int HOLD_LSB   = 24;

  // Fixed part of the SDA hold delay, in clocks.
  localparam int HOLD_FIXED = 3;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

endpackage

// File: rtl/scl_len_calc.sv
module scl_len_calc
  import scl_gen_pkg::*;
#(
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 6,
  parameter int OFFSET  = 4,
  parameter int LEN_W   = 16
) (
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [LEN_W-1:0] len_o
);

  logic             sat_w;
  logic [EXP_W-1:0] exp_c_w;
  logic [DIV_W-1:0] div_c_w;

  always_comb begin
    sat_w   = (exp_i > EXP_W'(EXP_MAX));
    exp_c_w = sat_w ? EXP_W'(EXP_MAX) : exp_i;
    div_c_w = sat_w ? {DIV_W{1'b1}} : div_i;
    len_o   = (LEN_W'(div_c_w) << exp_c_w) + LEN_W'(OFFSET);
  end

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
  import scl_gen_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stretch_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  output logic             scl_o,
  output logic             idle_o,
  output logic             in_low_o,
  output logic             enter_low_o
);

  logic             idle_q, idle_n;
  scl_phase_e       phase_q, phase_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             cnt_en_w;
  logic             last_w;

  // The count only moves when not frozen by an external stretch in high.
  assign cnt_en_w = !(run_i && !idle_q && (phase_q == PH_HIGH) && stretch_i);
  assign last_w   = (cnt_q == '0);

  always_comb begin
    idle_n      = idle_q;
    phase_n     = phase_q;
    cnt_n       = cnt_q;
    enter_low_o = 1'b0;
    if (!run_i) begin
      idle_n  = 1'b1;
      phase_n = PH_HIGH;
      cnt_n   = '0;
    end else if (idle_q) begin
      idle_n      = 1'b0;
      phase_n     = PH_LOW;
      cnt_n       = low_len_i - LEN_W'(1);
      enter_low_o = 1'b1;
    end else if (cnt_en_w) begin
      if (last_w) begin
        if (phase_q == PH_LOW) begin
          phase_n = PH_HIGH;
          cnt_n   = high_len_i - LEN_W'(1);
        end else begin
          phase_n     = PH_LOW;
          cnt_n       = low_len_i - LEN_W'(1);
          enter_low_o = 1'b1;
        end
      end else begin
        cnt_n = cnt_q - LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q  <= 1'b1;
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
    end else begin
      idle_q  <= idle_n;
      phase_q <= phase_n;
      if (cnt_en_w || !run_i) begin
        cnt_q <= cnt_n;
      end
    end
  end

  assign scl_o    = idle_q || (phase_q == PH_HIGH);
  assign idle_o   = idle_q;
  assign in_low_o = !idle_q && (phase_q == PH_LOW);

endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer
  import scl_gen_pkg::*;
#(
  parameter int HOLD_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic              in_low_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              strobe_o
);

  localparam int HCNT_W = HOLD_W + 2;

  logic [HCNT_W-1:0] hcnt_q, hcnt_n;
  logic              strobe_q, strobe_n;

  always_comb begin
    hcnt_n = hcnt_q;
    if (!run_i) begin
      hcnt_n = '0;
    end else if (load_i) begin
      hcnt_n = HCNT_W'(hold_i) + HCNT_W'(HOLD_FIXED);
    end else if (!in_low_i) begin
      hcnt_n = '0;
    end else if (hcnt_q != '0) begin
      hcnt_n = hcnt_q - HCNT_W'(1);
    end
    strobe_n = run_i && in_low_i && (hcnt_q == HCNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      hcnt_q   <= hcnt_n;
      strobe_q <= strobe_n;
    end
  end

  assign strobe_o = strobe_q;

endmodule

// File: rtl/scl_waveform_gen.sv
module scl_waveform_gen
  import scl_gen_pkg::*;
#(
  parameter int EXP_W   = 3,
  parameter int EXP_MAX = 6,
  parameter int HOLD_W  = 6,
  parameter int OFFSET  = 4,
  parameter int CFG_W   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             stretch_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             scl_o,
  output logic             sda_chg_o
);

  localparam int LEN_W = DIV_W + EXP_MAX + 2;

  logic [LEN_W-1:0] len_w [2];
  logic             idle_w;
  logic             in_low_w;
  logic             enter_low_w;
  logic             unused_cfg_w;

  // Index 0 computes the low-phase length, index 1 the high-phase length.
  for (genvar g = 0; g < 2; g++) begin : g_len
    localparam int DLSB = (g == 0) ? LO_DIV_LSB : HI_DIV_LSB;
    scl_len_calc #(
      .EXP_W  (EXP_W),
      .EXP_MAX(EXP_MAX),
      .OFFSET (OFFSET),
      .LEN_W  (LEN_W)
    ) u_calc (
      .div_i(cfg_i[DLSB +: DIV_W]),
      .exp_i(cfg_i[EXP_LSB +: EXP_W]),
      .len_o(len_w[g])
    );
  end

  scl_phase_timer #(
    .LEN_W(LEN_W)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .stretch_i  (stretch_i),
    .low_len_i  (len_w[0]),
    .high_len_i (len_w[1]),
    .scl_o      (scl_o),
    .idle_o     (idle_w),
    .in_low_o   (in_low_w),
    .enter_low_o(enter_low_w)
  );

  sda_hold_timer #(
    .HOLD_W(HOLD_W)
  ) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .load_i  (enter_low_w),
    .in_low_i(in_low_w),
    .hold_i  (cfg_i[HOLD_LSB +: HOLD_W]),
    .strobe_o(sda_chg_o)
  );

  assign unused_cfg_w = ^{cfg_i[HOLD_LSB-1:EXP_LSB+EXP_W], cfg_i[CFG_W-1:HOLD_LSB+HOLD_W]};

endmodule

// File: rtl/scl_waveform_gen_chk.sv
module scl_waveform_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic stretch,
  input logic scl,
  input logic strobe,
  input logic idle
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl && !strobe)); // R10

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && idle) |=> !scl); // R2

  AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !idle && scl && stretch) |=> scl); // R8

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R6

  AST_STROBE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(!scl)); // R6

endmodule

bind scl_waveform_gen scl_waveform_gen_chk u_chk (
  .clk    (clk_i),
  .rst_n  (rst_ni),
  .run    (run_i),
  .stretch(stretch_i),
  .scl    (scl_o),
  .strobe (sda_chg_o),
  .idle   (idle_w)
);

// File: tb/tb_scl_waveform_gen.sv
`timescale 1ns/1ps
module tb_scl_waveform_gen;

  localparam int EXP_MAX = 6;
  localparam int OFFSET  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        run_i;
  logic        stretch_i;
  logic [31:0] cfg_i;
  logic        scl_o;
  logic        sda_chg_o;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  scl_waveform_gen dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .stretch_i(stretch_i),
    .cfg_i    (cfg_i),
    .scl_o    (scl_o),
    .sda_chg_o(sda_chg_o)
  );

  function automatic int ref_len(int d, int e);
    int dd = d;
    int ee = e;
    if (ee > EXP_MAX) begin
      ee = EXP_MAX;
      dd = 255;
    end
    return dd * (1 << ee) + OFFSET;
  endfunction

  function automatic logic [31:0] mk_cfg(int lo, int hi, int e, int h);
    return (32'(h) << 24) | (32'(e) << 16) | (32'(hi) << 8) | 32'(lo);
  endfunction

  // Behavioural reference: phase flag, elapsed cycles, target strobe time.
  bit m_idle, m_high, m_strobe;
  int m_el, m_len, m_tgt;

  task automatic compare(logic exp_scl, logic exp_stb);
    vectors++;
    if (scl_o !== exp_scl || sda_chg_o !== exp_stb) begin
      miscompares++;
      $display("FAIL %s t=%0t scl/strobe actual %b%b expected %b%b",
               cur_req, $time, scl_o, sda_chg_o, exp_scl, exp_stb);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_idle = 1'b1; m_high = 1'b1; m_strobe = 1'b0;
      m_el = 0; m_len = 0; m_tgt = 0;
    end else begin
      if (!run_i) begin
        m_idle = 1'b1; m_high = 1'b1; m_strobe = 1'b0;
      end else if (m_idle) begin
        m_idle = 1'b0; m_high = 1'b0; m_el = 0; m_strobe = 1'b0;
        m_len = ref_len(int'(cfg_i[7:0]), int'(cfg_i[18:16]));
        m_tgt = int'(cfg_i[29:24]) + 3;
      end else begin
        m_strobe = !m_high && (m_el + 1 == m_tgt);
        if (!m_high || !stretch_i) begin
          m_el++;
          if (m_el == m_len) begin
            m_high = !m_high;
            m_el = 0;
            if (m_high) m_len = ref_len(int'(cfg_i[15:8]), int'(cfg_i[18:16]));
            else begin
              m_len = ref_len(int'(cfg_i[7:0]), int'(cfg_i[18:16]));
              m_tgt = int'(cfg_i[29:24]) + 3;
            end
          end
        end
      end
      #1;
      if (rst_ni && !done) compare(m_idle || m_high, m_strobe);
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog expired during %s", cur_req);
    summary();
  end

  initial begin
    rst_ni = 1'b0; run_i = 1'b0; stretch_i = 1'b0; cfg_i = '0;
    cycles(3);
    cur_req = "R1";
    compare(1'b1, 1'b0);        // R1 reset state
    rst_ni = 1'b1;
    cycles(5);                  // R1 idle with run low

    cur_req = "R3";             // low 7, high 9, strobe 3 after fall (R6)
    cfg_i = mk_cfg(3, 5, 0, 0);
    run_i = 1'b1;
    cycles(60);

    cur_req = "R9";             // change lands mid-phase
    cfg_i = mk_cfg(1, 2, 2, 2);
    cycles(80);

    cur_req = "R6";
    cfg_i = mk_cfg(2, 1, 1, 5); // low 8, hold 8: strobe at the rising edge
    cycles(60);

    cur_req = "R7";             // low 5, hold 13 suppressed
    cfg_i = mk_cfg(1, 1, 0, 10);
    cycles(60);

    cur_req = "R5";             // zero divisors: OFFSET clocks each
    cfg_i = mk_cfg(0, 0, 0, 0);
    cycles(40);

    cur_req = "R8";             // stretch freezes high, ignored in low
    cfg_i = mk_cfg(2, 3, 1, 1);
    for (int i = 0; i < 120; i++) begin
      stretch_i = (i % 7) < 3;
      @(negedge clk_i);
    end
    stretch_i = 1'b0;

    cur_req = "R3";             // exponent at its maximum, not clamped
    cfg_i = mk_cfg(1, 2, 6, 0);
    cycles(400);

    cur_req = "R10";
    run_i = 1'b0;
    cycles(6);

    cur_req = "R2";
    cfg_i = mk_cfg(4, 2, 0, 1);
    run_i = 1'b1;
    cycles(40);

    cur_req = "R4";             // exponent above max: 255 x 64 + 4
    run_i = 1'b0;
    cycles(2);
    cfg_i = mk_cfg(3, 9, 7, 20);
    run_i = 1'b1;
    cycles(2 * 16324 + 200);

    cur_req = "R10";
    run_i = 1'b0;
    cycles(4);
    summary();
  end

endmodule